// File: doc/BRIEF.md
# Power-of-Two Timing Strobe Generator

This block turns one fast master clock into four timing strobes, each a one-cycle clock enable: one paces encoder sampling, one paces a pulse-frequency-modulation output stage, and one each paces a DAC and an ADC serial link. Each strobe runs at the master rate divided by 2^N, where N is a 3-bit code from 0 to 7. The two converter channels also get a divided clock with 50% duty, for driving their serial shift clocks.

All four codes sit in one 12-bit configuration word. Software writes the word through a single-cycle write port and can read the active word back. A single free-running 7-bit counter serves all four channels, so strobes of different ratios always line up with each other. A newly written word waits in a shadow register until the counter wraps. This means a ratio change never shortens a strobe interval and never fires a strobe twice.

The blocks that consume the strobes (encoder counting, pulse generation, converter shifting) sit outside this block. The encoder strobe bounds the downstream count rate to one count per strobe. The pulse stage can emit at most one pulse every four of its strobes.

Top module: `clk_strobe_gen`

## Requirements
- R1: Field positions in the configuration word: bits [2:0] are the encoder sample code, [5:3] the PFM code, [8:6] the DAC code and [11:9] the ADC code.
- R2: With code N, a strobe is high for one cycle every 2^N master cycles, with all gaps equal (2, 4, ... 128 cycles for N = 1 ... 7).
- R3: With code 0, the strobe is high on every master cycle.
- R4: A synchronous active-high reset clears the counter and loads the word 0x8D2 (encoder 2, PFM 2, DAC 3, ADC 4). A write while reset is high is ignored. After release, the first encoder and PFM strobes come on the 3rd cycle, the first DAC strobe on the 7th and the first ADC strobe on the 15th.
- R5: A written word goes into a shadow register. The read-back port shows the active word, which is unchanged in the cycle after a write and changes only when the counter passes from its all-ones value to zero.
- R6: In the cycle before a new word takes effect, all four strobes are high. The first gap after the change equals the new period, so no interval is shortened or duplicated.
- R7: For code N ≥ 1, each converter clock has period 2^N and 50% duty, and it is high whenever its strobe is high. For code 0 it stays high.
- R8: Strobes are phase-aligned: whenever the strobe of a channel with code Ni is high, every channel with code Nj ≤ Ni also has its strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 12 | Configuration word to write |
| cfg_rdata | output | 12 | Active configuration word |
| enc_stb | output | 1 | Encoder sample strobe |
| pfm_stb | output | 1 | Pulse-frequency-modulation strobe |
| dac_stb | output | 1 | DAC serial strobe |
| adc_stb | output | 1 | ADC serial strobe |
| dac_clk | output | 1 | Divided clock for the DAC link |
| adc_clk | output | 1 | Divided clock for the ADC link |

## Verification
The main function is tried with eight configuration words that rotate the codes. Every channel therefore sees every code from 0 to 7 once, and no two channels share a code within a word. A field wired to the wrong bits, or an off-by-one in the divide ratio, shows up as a wrong strobe count or a wrong gap. The converter clocks are counted for duty and checked against their strobes, and mixed codes in one word expose any loss of phase alignment. Two mid-stream changes, one from a short period to a long one and one from a long period to a short one, separate a correctly deferred switch from an early one or one that clips a gap. Reset is tried from the idle state and again from a running configuration with a write held during reset.

// File: rtl/strobe_gen_pkg.sv
package strobe_gen_pkg;
    localparam int CODE_W  = 3;
    localparam int NUM_CH  = 4;
    localparam int NUM_CNV = 2;
    localparam int CFG_W   = CODE_W * NUM_CH;
    localparam int CNT_W   = (1 << CODE_W) - 1;
    // field order is decoded by the taps: encoder, PFM, DAC, ADC from bit 0 up
    localparam int CH_ENC  = 0;
    localparam int CH_PFM  = 1;
    localparam int CH_DAC  = 2;
    localparam int CH_ADC  = 3;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 12'h8D2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CFG_W-1:0]  cfg_t;
endpackage

// File: rtl/sg_counter.sv
module sg_counter
    import strobe_gen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output cnt_t cnt_o,
    output logic wrap_o
);
    typedef struct packed {
        cnt_t cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = &st_q.cnt;
endmodule

// File: rtl/sg_cfg_shadow.sv
module sg_cfg_shadow
    import strobe_gen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cfg_t wr_word,
    input  logic wrap,
    output cfg_t active_o
);
    typedef struct packed {
        cfg_t pending;
        cfg_t active;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.pending = wr_word;
        end
        if (wrap) begin
            st_d.active = st_q.pending;
        end
        if (rst) begin
            st_d.pending = CFG_DEFAULT;
            st_d.active  = CFG_DEFAULT;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/sg_strobe_tap.sv
module sg_strobe_tap
    import strobe_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code,
    input  cnt_t  cnt,
    output logic  stb_o
);
    logic [CNT_W:0] low_mask;

    always_comb begin
        low_mask = ((CNT_W + 1)'(1) << code) - 1'b1;
        stb_o    = &(cnt | ~low_mask[CNT_W-1:0]);
    end

    AST_ZERO_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |-> stb_o); // R3

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> (!stb_o || code == '0)); // R2
endmodule

// File: rtl/sg_clk_tap.sv
module sg_clk_tap
    import strobe_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code,
    input  cnt_t  cnt,
    input  logic  stb,
    output logic  div_clk_o
);
    logic [CNT_W:0] tap_vec;

    always_comb begin
        tap_vec   = {cnt, 1'b1};
        div_clk_o = tap_vec[code];
    end

    AST_CLK_HIGH_AT_STB: assert property (@(posedge clk) disable iff (rst)
        stb |-> div_clk_o); // R7
endmodule

// File: rtl/clk_strobe_gen.sv
module clk_strobe_gen
    import strobe_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [11:0] cfg_wdata,
    output logic [11:0] cfg_rdata,
    output logic        enc_stb,
    output logic        pfm_stb,
    output logic        dac_stb,
    output logic        adc_stb,
    output logic        dac_clk,
    output logic        adc_clk
);
    cnt_t                cnt;
    logic                wrap;
    cfg_t                active;
    code_t               code_w [NUM_CH];
    logic [NUM_CH-1:0]   stb_w;
    logic [NUM_CNV-1:0]  cnv_clk_w;

    sg_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    sg_cfg_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_word  (cfg_wdata),
        .wrap     (wrap),
        .active_o (active)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign code_w[i] = active[i*CODE_W +: CODE_W];
        sg_strobe_tap u_tap (
            .clk   (clk),
            .rst   (rst),
            .code  (code_w[i]),
            .cnt   (cnt),
            .stb_o (stb_w[i])
        );
    end

    for (genvar j = 0; j < NUM_CNV; j++) begin : g_cnv
        sg_clk_tap u_clk (
            .clk       (clk),
            .rst       (rst),
            .code      (code_w[CH_DAC + j]),
            .cnt       (cnt),
            .stb       (stb_w[CH_DAC + j]),
            .div_clk_o (cnv_clk_w[j])
        );
    end

    assign cfg_rdata = active;
    assign enc_stb   = stb_w[CH_ENC];
    assign pfm_stb   = stb_w[CH_PFM];
    assign dac_stb   = stb_w[CH_DAC];
    assign adc_stb   = stb_w[CH_ADC];
    assign dac_clk   = cnv_clk_w[0];
    assign adc_clk   = cnv_clk_w[1];

    AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata != $past(cfg_rdata)) |-> (cnt == '0)); // R5

    AST_ALL_STB_BEFORE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (&stb_w)); // R6

    for (genvar a = 0; a < NUM_CH; a++) begin : g_al_a
        for (genvar b = 0; b < NUM_CH; b++) begin : g_al_b
            if (a != b) begin : g_pair
                AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (rst)
                    (stb_w[a] && code_w[a] >= code_w[b]) |-> stb_w[b]); // R8
            end
        end
    end
endmodule

// File: tb/clk_strobe_gen_test.sv
module clk_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        enc_stb, pfm_stb, dac_stb, adc_stb, dac_clk, adc_clk;

    int n_checks = 0;
    int n_fails  = 0;

    // rotating codes {adc, dac, pfm, enc}: every channel sees every code
    localparam logic [11:0] VEC_TBL [8] = '{
        {3'd3, 3'd2, 3'd1, 3'd0},
        {3'd4, 3'd3, 3'd2, 3'd1},
        {3'd5, 3'd4, 3'd3, 3'd2},
        {3'd6, 3'd5, 3'd4, 3'd3},
        {3'd7, 3'd6, 3'd5, 3'd4},
        {3'd0, 3'd7, 3'd6, 3'd5},
        {3'd1, 3'd0, 3'd7, 3'd6},
        {3'd2, 3'd1, 3'd0, 3'd7}
    };

    clk_strobe_gen uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .enc_stb   (enc_stb),
        .pfm_stb   (pfm_stb),
        .dac_stb   (dac_stb),
        .adc_stb   (adc_stb),
        .dac_clk   (dac_clk),
        .adc_clk   (adc_clk)
    );

    always #5 clk = ~clk;

    function automatic int fcode(input logic [11:0] w, input int ch);
        return int'(w[ch*3 +: 3]);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit write_during);
        int first [4];
        logic [3:0] s;
        @(negedge clk);
        rst = 1'b1;
        cfg_we = write_during;
        cfg_wdata = 12'hFFF;
        repeat (2) @(negedge clk);
        check(cfg_rdata == 12'h8D2, "R4", "word during reset", cfg_rdata, 12'h8D2);
        cfg_we = 1'b0;
        rst = 1'b0;
        for (int c = 0; c < 4; c++) first[c] = -1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            s = {adc_stb, dac_stb, pfm_stb, enc_stb};
            for (int c = 0; c < 4; c++) if (s[c] && first[c] < 0) first[c] = k;
        end
        check(cfg_rdata == 12'h8D2, "R4", "word after release", cfg_rdata, 12'h8D2);
        check(first[0] == 3, "R4", "first encoder strobe", first[0], 3);
        check(first[1] == 3, "R4", "first PFM strobe", first[1], 3);
        check(first[2] == 7, "R4", "first DAC strobe", first[2], 7);
        check(first[3] == 15, "R4", "first ADC strobe", first[3], 15);
    endtask

    task automatic apply_cfg(input logic [11:0] w);
        int waited = 0;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        while (cfg_rdata != w && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        check(cfg_rdata == w, "R5", "word reaches read-back", cfg_rdata, w);
    endtask

    task automatic measure(input logic [11:0] w);
        int cnt_s [4];
        int last [4];
        int bad [4];
        int hi [2];
        int mis = 0;
        int misalign = 0;
        logic [3:0] s;
        logic [1:0] c;
        for (int ch = 0; ch < 4; ch++) begin
            cnt_s[ch] = 0; last[ch] = -1; bad[ch] = 0;
        end
        hi[0] = 0; hi[1] = 0;
        for (int t = 0; t < 256; t++) begin
            @(negedge clk);
            s = {adc_stb, dac_stb, pfm_stb, enc_stb};
            c = {adc_clk, dac_clk};
            for (int ch = 0; ch < 4; ch++) begin
                if (s[ch]) begin
                    cnt_s[ch]++;
                    if (last[ch] >= 0 && (t - last[ch]) != (1 << fcode(w, ch))) bad[ch]++;
                    last[ch] = t;
                end
            end
            for (int j = 0; j < 2; j++) begin
                hi[j] += int'(c[j]);
                if (s[2+j] && !c[j]) mis++;
            end
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    if (s[a] && fcode(w, a) >= fcode(w, b) && !s[b]) misalign++;
        end
        for (int ch = 0; ch < 4; ch++) begin
            check(cnt_s[ch] == (256 >> fcode(w, ch)) && bad[ch] == 0, "R1 R2",
                  $sformatf("strobes of channel %0d in 256 cycles (bad gaps %0d)", ch, bad[ch]),
                  cnt_s[ch], 256 >> fcode(w, ch));
            if (fcode(w, ch) == 0)
                check(cnt_s[ch] == 256, "R3", "code 0 strobe every cycle", cnt_s[ch], 256);
        end
        for (int j = 0; j < 2; j++)
            check(hi[j] == ((fcode(w, 2+j) == 0) ? 256 : 128), "R7",
                  $sformatf("converter clock %0d high cycles", j), hi[j],
                  (fcode(w, 2+j) == 0) ? 256 : 128);
        check(mis == 0, "R7", "converter clock low while strobe high", mis, 0);
        check(misalign == 0, "R8", "phase misaligned samples", misalign, 0);
    endtask

    task automatic glitch(input logic [11:0] wa, input logic [11:0] wb);
        int last [4];
        int bad = 0;
        bit switched = 0;
        bit prev_all = 0;
        logic [3:0] s;
        apply_cfg(wa);
        repeat (37) @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = wb;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == wa, "R5", "read-back right after write", cfg_rdata, wa);
        for (int ch = 0; ch < 4; ch++) last[ch] = -1;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            s = {adc_stb, dac_stb, pfm_stb, enc_stb};
            if (!switched && cfg_rdata == wb) begin
                switched = 1;
                check(prev_all, "R6", "all strobes high before switch", int'(prev_all), 1);
            end
            for (int ch = 0; ch < 4; ch++) begin
                if (s[ch]) begin
                    if (last[ch] >= 0 && (t - last[ch]) != (1 << fcode(cfg_rdata, ch))) bad++;
                    last[ch] = t;
                end
            end
            prev_all = &s;
        end
        check(switched, "R5", "new word took effect", int'(switched), 1);
        check(bad == 0, "R6", "gaps not matching active period", bad, 0);
    endtask

    initial begin
        do_reset(1'b0);
        measure(12'h8D2);
        for (int v = 0; v < 8; v++) begin
            apply_cfg(VEC_TBL[v]);
            measure(VEC_TBL[v]);
        end
        glitch({3'd3, 3'd3, 3'd3, 3'd3}, {3'd7, 3'd0, 3'd1, 3'd5});
        glitch({3'd6, 3'd6, 3'd6, 3'd6}, {3'd1, 3'd2, 3'd0, 3'd1});
        do_reset(1'b1);
        measure(12'h8D2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule